// File: doc/BRIEF.md
# Coherent Store Ownership Upgrade Controller

This block manages a single cache line inside a coherent cache master. It receives stores from the core and makes sure the line is held with exclusive ownership before any store lands in it. When the line is already unique, the store commits at once. When the line is shared or absent, the block sends an ownership request on a simplified read-address channel and waits for the read response. It then commits the store and sends a one-cycle read acknowledge that closes the transaction.

A shared line may be dirty with respect to memory and still match every other cached copy. For that reason, an upgrade from a shared state needs no data transfer. A partial store to a shared line uses a clean-and-claim request. A full-line store uses a claim-without-data request. A store to an invalid line uses a fetch-with-ownership request. Only one request is outstanding at a time.

Snoops can arrive at any time, including while an upgrade is pending. A snoop is always accepted and answered one cycle later with the line's presence and dirtiness. If an invalidation takes the line away during a clean-and-claim request, the block does not write into an invalid line. It closes the first transaction and then re-issues the request as a fetch-with-ownership.

Top module: `store_upgrade_ctrl`

## Requirements
- R1: After reset the line state is Invalid (code 0). `pending_o`, `ar_valid_o`, `rack_o`, `st_done_o` and `snp_rsp_valid_o` are all low.
- R2: A store accepted while the line is UniqueClean (3) or UniqueDirty (4) issues no request. `st_done_o` pulses in the following cycle, with the line already UniqueDirty, and no `rack_o` follows.
- R3: A store accepted while the line is SharedClean (1) or SharedDirty (2) raises `ar_valid_o` in the next cycle. `ar_op_o` is 0 (clean-and-claim) for a partial store and 1 (claim-without-data) when `st_full_i` is set. The line state does not change before the response, and `ar_valid_o` and `ar_op_o` hold until `ar_ready_i`.
- R4: A store accepted while the line is Invalid requests with `ar_op_o` = 2 (fetch-with-ownership), or 1 when `st_full_i` is set.
- R5: One cycle after `r_valid_i`, `st_done_o` pulses and the line reads UniqueDirty (4). In the cycle after that, `rack_o` pulses for exactly one cycle. `pending_o` falls in the cycle after `rack_o`.
- R6: Only one request is outstanding. `ar_valid_o` stays low from the address handshake until `rack_o`, and `st_ready_o` is low whenever a store is in progress.
- R7: Every snoop is answered one cycle later with `snp_rsp_valid_o` high. `snp_rsp_hit_o` reports whether the line state was not Invalid. `snp_rsp_dirty_o` reports whether the state was SharedDirty or UniqueDirty.
- R8: An invalidating snoop sets the line to Invalid. A non-invalidating snoop moves UniqueClean to SharedClean and UniqueDirty to SharedDirty, and leaves other states unchanged.
- R9: If an invalidating snoop removes the line while a claim-without-data request is pending, the store still commits after that request's response, and the line ends UniqueDirty.
- R10: If an invalidating snoop removes a present line while a clean-and-claim request is pending, the response is followed by `rack_o` with no `st_done_o`. A fetch-with-ownership request (op 2) is then issued, and the store commits only after that second response.
- R11: A store is not accepted in a cycle where `snp_valid_i` is high, so `st_ready_o` is low in that cycle.
- R12: `fill_valid_i` loads `fill_state_i` (legal codes 0 to 4) into the line only when no store is in progress, no snoop is present and no store is being accepted. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fill_valid_i | input | 1 | Load a line state from the fill path |
| fill_state_i | input | 3 | Line state to load |
| st_valid_i | input | 1 | Store request from the core |
| st_full_i | input | 1 | Store overwrites the whole line |
| st_ready_o | output | 1 | Store accepted this cycle when valid |
| st_done_o | output | 1 | Store commits into the line this cycle |
| ar_valid_o | output | 1 | Ownership request valid |
| ar_ready_i | input | 1 | Ownership request accepted |
| ar_op_o | output | 2 | Request kind: 0 clean-and-claim, 1 claim-without-data, 2 fetch-with-ownership |
| r_valid_i | input | 1 | Response to the outstanding request |
| rack_o | output | 1 | Read acknowledge pulse |
| snp_valid_i | input | 1 | Snoop to this line |
| snp_inv_i | input | 1 | Snoop invalidates the line |
| snp_rsp_valid_o | output | 1 | Snoop response valid |
| snp_rsp_hit_o | output | 1 | Line was present at the snoop |
| snp_rsp_dirty_o | output | 1 | Line was dirty at the snoop |
| line_state_o | output | 3 | Line state: 0 I, 1 SC, 2 SD, 3 UC, 4 UD |
| pending_o | output | 1 | An ownership upgrade is in progress |

## Verification
The hardest case to reach is an invalidation that lands inside the window of a clean-and-claim request, because it forces the close-and-reissue path. The stimulus first fills a shared line and issues a partial store. While `ar_valid_o` is still waiting on a held-back `ar_ready_i`, it injects the invalidating snoop, then completes both transactions in turn. A second case places the invalidation after the address handshake of a claim-without-data request, and checks that the store commits without a retry.

// File: rtl/sup_pkg.sv
package sup_pkg;
  localparam int unsigned LS_W = 3;
  localparam int unsigned OP_W = 2;
  localparam int unsigned PH_W = 3;

  typedef enum logic [LS_W-1:0] {
    LS_I  = 3'd0,
    LS_SC = 3'd1,
    LS_SD = 3'd2,
    LS_UC = 3'd3,
    LS_UD = 3'd4
  } line_st_e;

  typedef enum logic [OP_W-1:0] {
    OP_CLAIM_CLEAN = 2'd0,
    OP_CLAIM_FULL  = 2'd1,
    OP_FETCH_OWN   = 2'd2
  } up_op_e;

  typedef enum logic [PH_W-1:0] {
    PH_IDLE,
    PH_REQ,
    PH_WAIT,
    PH_COMMIT,
    PH_ACK
  } ph_e;
endpackage

// File: rtl/sup_snoop.sv
module sup_snoop
  import sup_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     snp_valid_i,
  input  logic     snp_inv_i,
  input  line_st_e line_i,
  output line_st_e snp_next_o,
  output logic     snp_inv_hit_o,
  output logic     rsp_valid_o,
  output logic     rsp_hit_o,
  output logic     rsp_dirty_o
);
  logic present, dirty;

  always_comb begin
    present = (line_i != LS_I);
    dirty   = (line_i == LS_SD) || (line_i == LS_UD);
    snp_inv_hit_o = snp_valid_i & snp_inv_i & present;
    if (snp_inv_i) begin
      snp_next_o = LS_I;
    end else begin
      unique case (line_i)
        LS_UC:   snp_next_o = LS_SC;
        LS_UD:   snp_next_o = LS_SD;
        default: snp_next_o = line_i;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_dirty_o <= 1'b0;
    end else begin
      rsp_valid_o <= snp_valid_i;
      rsp_hit_o   <= snp_valid_i & present;
      rsp_dirty_o <= snp_valid_i & dirty;
    end
  end
endmodule

// File: rtl/sup_line.sv
module sup_line
  import sup_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     commit_i,
  input  logic     snp_valid_i,
  input  line_st_e snp_next_i,
  input  logic     fill_en_i,
  input  line_st_e fill_state_i,
  output line_st_e line_o
);
  line_st_e line_d;

  // commit beats snoop beats fill
  always_comb begin
    line_d = line_o;
    if (commit_i)         line_d = LS_UD;
    else if (snp_valid_i) line_d = snp_next_i;
    else if (fill_en_i)   line_d = fill_state_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_o <= LS_I;
    else         line_o <= line_d;
  end
endmodule

// File: rtl/sup_seq.sv
module sup_seq
  import sup_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     st_valid_i,
  input  logic     st_full_i,
  input  logic     snp_valid_i,
  input  logic     snp_inv_hit_i,
  input  logic     ar_ready_i,
  input  logic     r_valid_i,
  input  line_st_e line_i,
  output logic     st_ready_o,
  output logic     st_accept_o,
  output logic     ar_valid_o,
  output up_op_e   ar_op_o,
  output logic     rack_o,
  output logic     st_done_o,
  output logic     pending_o,
  output logic     commit_o,
  output logic     idle_o
);
  ph_e    ph_q, ph_d;
  up_op_e op_q, op_d;
  logic   pend_q, pend_d, upg_q, upg_d, lost_q, lost_d, retry_q, retry_d;
  logic   uniq, shrd, in_flight, lost_any;

  always_comb begin
    uniq      = (line_i == LS_UC) || (line_i == LS_UD);
    shrd      = (line_i == LS_SC) || (line_i == LS_SD);
    in_flight = (ph_q == PH_REQ) || (ph_q == PH_WAIT);
    lost_any  = lost_q | (snp_inv_hit_i & in_flight);

    idle_o      = (ph_q == PH_IDLE);
    st_ready_o  = idle_o & ~snp_valid_i;
    st_accept_o = st_ready_o & st_valid_i;

    ph_d     = ph_q;
    op_d     = op_q;
    pend_d   = pend_q;
    upg_d    = upg_q;
    lost_d   = in_flight ? lost_any : lost_q;
    retry_d  = retry_q;
    commit_o = 1'b0;

    unique case (ph_q)
      PH_IDLE: begin
        if (st_accept_o) begin
          if (uniq) begin
            ph_d     = PH_COMMIT;
            upg_d    = 1'b0;
            commit_o = 1'b1;
          end else begin
            ph_d   = PH_REQ;
            pend_d = 1'b1;
            upg_d  = 1'b1;
            lost_d = 1'b0;
            if (st_full_i) op_d = OP_CLAIM_FULL;
            else if (shrd) op_d = OP_CLAIM_CLEAN;
            else           op_d = OP_FETCH_OWN;
          end
        end
      end
      PH_REQ: begin
        if (ar_ready_i) ph_d = PH_WAIT;
      end
      PH_WAIT: begin
        if (r_valid_i) begin
          // clean-and-claim on a lost line cannot take the write
          if ((op_q == OP_CLAIM_CLEAN) && lost_any) begin
            ph_d    = PH_ACK;
            retry_d = 1'b1;
          end else begin
            ph_d     = PH_COMMIT;
            commit_o = 1'b1;
          end
        end
      end
      PH_COMMIT: begin
        ph_d = upg_q ? PH_ACK : PH_IDLE;
      end
      PH_ACK: begin
        if (retry_q) begin
          ph_d    = PH_REQ;
          op_d    = OP_FETCH_OWN;
          retry_d = 1'b0;
          lost_d  = 1'b0;
        end else begin
          ph_d   = PH_IDLE;
          pend_d = 1'b0;
          upg_d  = 1'b0;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      op_q    <= OP_CLAIM_CLEAN;
      pend_q  <= 1'b0;
      upg_q   <= 1'b0;
      lost_q  <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      op_q    <= op_d;
      pend_q  <= pend_d;
      upg_q   <= upg_d;
      lost_q  <= lost_d;
      retry_q <= retry_d;
    end
  end

  assign ar_valid_o = (ph_q == PH_REQ);
  assign ar_op_o    = op_q;
  assign rack_o     = (ph_q == PH_ACK);
  assign st_done_o  = (ph_q == PH_COMMIT);
  assign pending_o  = pend_q;
endmodule

// File: rtl/store_upgrade_ctrl.sv
module store_upgrade_ctrl
  import sup_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fill_valid_i,
  input  logic [LS_W-1:0]     fill_state_i,
  input  logic                st_valid_i,
  input  logic                st_full_i,
  output logic                st_ready_o,
  output logic                st_done_o,
  output logic                ar_valid_o,
  input  logic                ar_ready_i,
  output logic [OP_W-1:0]     ar_op_o,
  input  logic                r_valid_i,
  output logic                rack_o,
  input  logic                snp_valid_i,
  input  logic                snp_inv_i,
  output logic                snp_rsp_valid_o,
  output logic                snp_rsp_hit_o,
  output logic                snp_rsp_dirty_o,
  output logic [LS_W-1:0]     line_state_o,
  output logic                pending_o
);
  line_st_e line_q, snp_next, fill_st;
  up_op_e   op;
  logic     snp_inv_hit, st_accept, commit, idle, fill_en;

  assign fill_st = line_st_e'(fill_state_i);
  assign fill_en = fill_valid_i & idle & ~snp_valid_i & ~st_accept &
                   (fill_state_i <= LS_W'(LS_UD));

  sup_snoop u_snoop (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .snp_valid_i   (snp_valid_i),
    .snp_inv_i     (snp_inv_i),
    .line_i        (line_q),
    .snp_next_o    (snp_next),
    .snp_inv_hit_o (snp_inv_hit),
    .rsp_valid_o   (snp_rsp_valid_o),
    .rsp_hit_o     (snp_rsp_hit_o),
    .rsp_dirty_o   (snp_rsp_dirty_o)
  );

  sup_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .st_valid_i    (st_valid_i),
    .st_full_i     (st_full_i),
    .snp_valid_i   (snp_valid_i),
    .snp_inv_hit_i (snp_inv_hit),
    .ar_ready_i    (ar_ready_i),
    .r_valid_i     (r_valid_i),
    .line_i        (line_q),
    .st_ready_o    (st_ready_o),
    .st_accept_o   (st_accept),
    .ar_valid_o    (ar_valid_o),
    .ar_op_o       (op),
    .rack_o        (rack_o),
    .st_done_o     (st_done_o),
    .pending_o     (pending_o),
    .commit_o      (commit),
    .idle_o        (idle)
  );

  sup_line u_line (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_i     (commit),
    .snp_valid_i  (snp_valid_i),
    .snp_next_i   (snp_next),
    .fill_en_i    (fill_en),
    .fill_state_i (fill_st),
    .line_o       (line_q)
  );

  assign ar_op_o      = op;
  assign line_state_o = line_q;
endmodule

// File: rtl/sup_chk.sv
module sup_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       st_ready_o,
  input logic       st_done_o,
  input logic       ar_valid_o,
  input logic       ar_ready_i,
  input logic [1:0] ar_op_o,
  input logic       r_valid_i,
  input logic       rack_o,
  input logic       snp_valid_i,
  input logic       snp_inv_i,
  input logic       snp_rsp_valid_o,
  input logic [2:0] line_state_o,
  input logic       pending_o
);
  logic outst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       outst_q <= 1'b0;
    else if (ar_valid_o && ar_ready_i) outst_q <= 1'b1;
    else if (rack_o)                   outst_q <= 1'b0;
  end

  // R6
  single_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outst_q |-> !ar_valid_o);

  // R3
  ar_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_valid_o && !ar_ready_i |=> ar_valid_o && $stable(ar_op_o));

  // R3
  no_early_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o && line_state_o != 3'd4 && !r_valid_i |=> line_state_o != 3'd4);

  // R5
  rack_after_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_done_o && pending_o |=> rack_o);

  // R5
  rack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rack_o |=> !rack_o);

  // R2
  commit_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_done_o |-> line_state_o == 3'd4);

  // R7
  snoop_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i |=> snp_rsp_valid_o);

  // R8
  snoop_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && snp_inv_i && !r_valid_i |=> line_state_o == 3'd0);

  // R11
  snoop_blocks_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i |-> !st_ready_o);
endmodule

bind store_upgrade_ctrl sup_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .st_ready_o      (st_ready_o),
  .st_done_o       (st_done_o),
  .ar_valid_o      (ar_valid_o),
  .ar_ready_i      (ar_ready_i),
  .ar_op_o         (ar_op_o),
  .r_valid_i       (r_valid_i),
  .rack_o          (rack_o),
  .snp_valid_i     (snp_valid_i),
  .snp_inv_i       (snp_inv_i),
  .snp_rsp_valid_o (snp_rsp_valid_o),
  .line_state_o    (line_state_o),
  .pending_o       (pending_o)
);

// File: tb/tb_store_upgrade_ctrl.sv
module tb_store_upgrade_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fill_valid = 0, st_valid = 0, st_full = 0, ar_ready = 0, r_valid = 0;
  logic snp_valid = 0, snp_inv = 0;
  logic [2:0] fill_state = 0;
  logic st_ready, st_done, ar_valid, rack, srv, shit, sdirty, pending;
  logic [1:0] ar_op;
  logic [2:0] line_st;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  store_upgrade_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .fill_valid_i(fill_valid), .fill_state_i(fill_state),
    .st_valid_i(st_valid), .st_full_i(st_full), .st_ready_o(st_ready), .st_done_o(st_done),
    .ar_valid_o(ar_valid), .ar_ready_i(ar_ready), .ar_op_o(ar_op), .r_valid_i(r_valid),
    .rack_o(rack), .snp_valid_i(snp_valid), .snp_inv_i(snp_inv),
    .snp_rsp_valid_o(srv), .snp_rsp_hit_o(shit), .snp_rsp_dirty_o(sdirty),
    .line_state_o(line_st), .pending_o(pending));

  // behavioural reference: phase 0 idle,1 request,2 wait,3 commit,4 ack
  int m_line, m_ph, m_op, m_pend, m_upg, m_lost, m_retry, m_srv, m_shit, m_sdirty;

  always @(posedge clk or negedge rst_n) begin
    int ln, ph, acc, lostnow;
    if (!rst_n) begin
      m_line = 0; m_ph = 0; m_op = 0; m_pend = 0; m_upg = 0; m_lost = 0;
      m_retry = 0; m_srv = 0; m_shit = 0; m_sdirty = 0;
    end else begin
      ln = m_line; ph = m_ph;
      m_srv = snp_valid; m_shit = snp_valid && ln != 0; m_sdirty = snp_valid && (ln == 2 || ln == 4);
      acc = (ph == 0 && !snp_valid && st_valid);
      lostnow = snp_valid && snp_inv && ln != 0 && (ph == 1 || ph == 2);
      if (lostnow) m_lost = 1;
      if (snp_valid) m_line = snp_inv ? 0 : (ln == 3 ? 1 : (ln == 4 ? 2 : ln));
      else if (fill_valid && ph == 0 && !acc && fill_state <= 4) m_line = fill_state;
      if (ph == 0 && acc) begin
        if (ln >= 3) begin m_ph = 3; m_upg = 0; m_line = 4; end
        else begin
          m_ph = 1; m_pend = 1; m_upg = 1; m_lost = 0;
          m_op = st_full ? 1 : (ln == 0 ? 2 : 0);
        end
      end else if (ph == 1) begin
        if (ar_ready) m_ph = 2;
      end else if (ph == 2) begin
        if (r_valid) begin
          if (m_op == 0 && m_lost) begin m_ph = 4; m_retry = 1; end
          else begin m_ph = 3; m_line = 4; end
        end
      end else if (ph == 3) m_ph = m_upg ? 4 : 0;
      else if (ph == 4) begin
        if (m_retry) begin m_ph = 1; m_op = 2; m_retry = 0; m_lost = 0; end
        else begin m_ph = 0; m_pend = 0; m_upg = 0; end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) if (rst_n && !finished) begin
    chk("R8 line_state", line_st, m_line);
    chk("R5 pending", pending, m_pend);
    chk("R3 ar_valid", ar_valid, m_ph == 1);
    if (m_ph == 1) chk("R4 ar_op", ar_op, m_op);
    chk("R5 rack", rack, m_ph == 4);
    chk("R2 st_done", st_done, m_ph == 3);
    chk("R11 st_ready", st_ready, m_ph == 0 && !snp_valid);
    chk("R7 snp_rsp_valid", srv, m_srv);
    if (m_srv) begin
      chk("R7 snp_rsp_hit", shit, m_shit);
      chk("R7 snp_rsp_dirty", sdirty, m_sdirty);
    end
  end

  task automatic tick(); @(posedge clk); #2; endtask
  task automatic fill(int s);
    fill_valid = 1; fill_state = 3'(s); tick(); fill_valid = 0;
  endtask
  task automatic store(bit full);
    st_valid = 1; st_full = full; tick(); st_valid = 0; st_full = 0;
  endtask
  task automatic snoop(bit inv);
    snp_valid = 1; snp_inv = inv; tick(); snp_valid = 0; snp_inv = 0;
  endtask
  task automatic ar_hs(); ar_ready = 1; tick(); ar_ready = 0; endtask
  task automatic resp(); r_valid = 1; tick(); r_valid = 0; endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 line reset", line_st, 0);
    chk("R1 pending reset", pending, 0);
    chk("R1 idle outputs", {ar_valid, rack, st_done, srv}, 0);
    rst_n = 1; tick();

    // unique hit
    fill(3);
    store(0);
    chk("R2 done no request", {st_done, ar_valid}, 2'b10);
    chk("R2 line UD", line_st, 4);
    tick(); chk("R2 no rack", rack, 0);

    // shared dirty partial store, ready held back
    fill(2);
    store(0);
    chk("R3 clean-claim op", ar_op, 0);
    st_valid = 1; tick(); tick(); st_valid = 0;
    chk("R3 line held", line_st, 2);
    chk("R6 busy not ready", st_ready, 0);
    ar_hs();
    tick(); chk("R6 no second request", ar_valid, 0);
    resp();
    chk("R5 commit", st_done, 1);
    chk("R5 line UD", line_st, 4);
    tick(); chk("R5 rack", rack, 1);
    tick(); chk("R5 rack single", rack, 0); chk("R5 pending cleared", pending, 0);

    // snoop reads
    snoop(0); chk("R8 UD to SD", line_st, 2); chk("R7 dirty hit", {shit, sdirty}, 2'b11);
    fill(3); snoop(0); chk("R8 UC to SC", line_st, 1); chk("R7 clean hit", {shit, sdirty}, 2'b10);

    // full store on shared, invalidated after handshake
    store(1);
    chk("R3 claim-full op", ar_op, 1);
    ar_hs();
    snoop(1);
    chk("R9 line lost", line_st, 0);
    resp();
    chk("R9 commit despite loss", st_done, 1);
    chk("R9 line UD", line_st, 4);
    tick(); tick();

    // partial store on shared, invalidated before handshake
    fill(1);
    store(0);
    snoop(1);
    chk("R10 line lost", line_st, 0);
    ar_hs(); resp();
    chk("R10 rack without commit", {rack, st_done}, 2'b10);
    tick();
    chk("R10 reissue fetch", {ar_valid, ar_op}, 3'b110);
    ar_hs(); resp();
    chk("R10 commit after retry", st_done, 1);
    tick(); tick();

    // invalid line
    snoop(1);
    store(0); chk("R4 fetch op", ar_op, 2);
    ar_hs(); resp(); tick(); tick();
    snoop(1);
    store(1); chk("R4 full op", ar_op, 1);
    fill(2); chk("R12 fill ignored busy", line_st, 0);
    ar_hs(); resp(); tick(); tick();

    // store with snoop, fill with snoop
    fill(3);
    st_valid = 1; snp_valid = 1;
    tick(); st_valid = 0; snp_valid = 0;
    chk("R11 store blocked", {st_done, ar_valid}, 0);
    chk("R8 UC share", line_st, 1);
    fill_valid = 1; fill_state = 4; snp_valid = 1; tick();
    fill_valid = 0; snp_valid = 0;
    chk("R12 fill ignored on snoop", line_st, 1);
    fill(0); chk("R12 fill idle", line_st, 0);
    tick();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule